// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block picks which of eight resident physical frames gives up its page when the memory manager needs a free frame. It uses the second-chance (clock) policy. The frames sit on a ring, and a hand register points at the next candidate. Each frame carries one referenced flag. The address translator raises that flag through a per-frame strobe whenever the page in that frame is read or written.

When a victim is requested, the hand sweeps the ring one frame per clock. A frame whose flag is set gets its flag cleared and is passed over. The first frame found with a clear flag is reported as the victim, and the hand then moves one position past it. If every flag was set, the first full turn clears them all, and the sweep ends on the frame where it began. Once the new page has been installed in the freed frame, a fill pulse marks the frame just behind the hand as referenced.

Only one search runs at a time. A request that arrives during a sweep is dropped.

Top module: `clock_victim_picker`

## Requirements
- R1: While reset is held and on the first cycle after it, `victim_done` is 0 and `victim_idx` is 0. The hand starts at frame 0 and every referenced flag is clear, so the first request returns frame 0.
- R2: A 1 on bit i of `ref_strobe` for one clock sets the referenced flag of frame i. A later sweep then passes over frame i instead of choosing it.
- R3: A search returns the first frame, starting at the hand and moving upward with wrap from 7 to 0, whose referenced flag is clear.
- R4: Each frame the hand passes over has its flag cleared, so a later search can choose it.
- R5: If a request is sampled on clock edge T and the sweep passes k flagged frames, `victim_done` is high in the cycle after edge T+1+k. When all eight flags are set and no new references arrive, k is 8 and the starting frame is returned.
- R6: After a victim is chosen, the hand points at the next frame (victim+1, with wrap), and the next search starts there.
- R7: A one-cycle `fill_en` pulse sets the referenced flag of the frame just behind the hand (hand-1, with wrap from 0 to 7).
- R8: When a strobe for a frame arrives in the same cycle as the hand clears that frame's flag, the flag stays set.
- R9: `victim_done` is a single-cycle pulse. Each accepted request yields exactly one pulse. A request raised while a search is running is ignored.
- R10: `victim_idx` holds its value between `victim_done` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_strobe | input | 8 | Per-frame reference strobe from the translator |
| victim_req | input | 1 | Request to choose a victim frame |
| fill_en | input | 1 | New page installed; marks the frame behind the hand as referenced |
| victim_idx | output | 3 | Index of the chosen frame |
| victim_done | output | 1 | One-cycle pulse when `victim_idx` is valid |

## Verification
Sweeps are run against four flag patterns:
- All flags clear: shows the search starts at the hand.
- A few scattered flags: shows flagged frames are skipped and that each skip costs exactly one cycle.
- All flags set: shows the full-revolution fallback and its worst-case latency.
- Flags left by a fill or by a strobe that lands on the frame being cleared: separates correct placement behind the hand and correct strobe priority from the alternatives, because each wrong variant moves the returned index or the latency.

A second request issued during a long sweep shows whether requests are dropped while busy. Follow-up searches then expose whether passed frames were really cleared.

// File: rtl/clkrep_pkg.sv
// Package: shared types for the clock replacement selector.
// Assumes nothing beyond a single clock domain.
package clkrep_pkg;

    // Sweep controller state encoding
    typedef enum logic [0:0] {
        SW_IDLE   = 1'b0,
        SW_SEARCH = 1'b1
    } sweep_state_e;

endpackage

// File: rtl/clkrep_hand.sv
// Module: circular hand pointer.
// Holds the index of the next candidate frame and advances it by one,
// wrapping at N-1. Also presents the index just behind the hand.
// Assumes N >= 2.
module clkrep_hand #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [IW-1:0] hand_q,
    output logic [IW-1:0] behind
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    // Purpose: advance the hand by one frame per step, wrapping around
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hand_q <= '0;
        end else if (step) begin
            hand_q <= (hand_q == LAST) ? '0 : hand_q + 1'b1;
        end
    end

    // Purpose: index of the frame one position behind the hand
    always_comb begin
        behind = (hand_q == '0) ? LAST : hand_q - 1'b1;
    end
endmodule

// File: rtl/clkrep_ref_bits.sv
// Module: referenced-flag array, one flag per frame.
// Set sources: translator strobe, fill of the frame behind the hand.
// Clear source: the sweep passing the frame under the hand.
// A set in the same cycle as a clear wins.
module clkrep_ref_bits #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  ref_strobe,
    input  logic          fill_en,
    input  logic [IW-1:0] behind,
    input  logic          clear_en,
    input  logic [IW-1:0] hand,
    output logic [N-1:0]  ref_q,
    output logic          cur_bit
);
    for (genvar i = 0; i < N; i++) begin : g_frame
        logic set_i;
        logic clr_i;

        // Purpose: decode set and clear requests for this frame
        always_comb begin
            set_i = ref_strobe[i] | (fill_en && (behind == IW'(i)));
            clr_i = clear_en && (hand == IW'(i));
        end

        // Purpose: hold the flag; set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ref_q[i] <= 1'b0;
            end else if (set_i) begin
                ref_q[i] <= 1'b1;
            end else if (clr_i) begin
                ref_q[i] <= 1'b0;
            end
        end
    end

    // Purpose: flag of the frame currently under the hand
    always_comb begin
        cur_bit = ref_q[hand];
    end
endmodule

// File: rtl/clkrep_sweep.sv
// Module: sweep controller.
// Accepts a request only when idle. While searching, each cycle it either
// clears the flagged frame under the hand or selects the unflagged one.
// The hand steps on every search cycle, so it ends one past the victim.
module clkrep_sweep #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          victim_req,
    input  logic          cur_bit,
    input  logic [IW-1:0] hand,
    output logic          step,
    output logic          clear_en,
    output logic [IW-1:0] victim_idx,
    output logic          victim_done
);
    import clkrep_pkg::*;

    sweep_state_e state_q;

    // Purpose: state, victim index and done pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SW_IDLE;
            victim_idx  <= '0;
            victim_done <= 1'b0;
        end else begin
            victim_done <= 1'b0;
            case (state_q)
                SW_IDLE: begin
                    if (victim_req) state_q <= SW_SEARCH;
                end
                SW_SEARCH: begin
                    if (!cur_bit) begin
                        victim_idx  <= hand;
                        victim_done <= 1'b1;
                        state_q     <= SW_IDLE;
                    end
                end
                default: state_q <= SW_IDLE;
            endcase
        end
    end

    // Purpose: per-cycle hand step and flag clear while searching
    always_comb begin
        step     = (state_q == SW_SEARCH);
        clear_en = (state_q == SW_SEARCH) && cur_bit;
    end
endmodule

// File: rtl/clock_victim_picker.sv
// Module: clock (second-chance) victim selector, top level.
// Wires the hand pointer, the flag array and the sweep controller.
// Assumes a single clock and a synchronous active-low reset.
module clock_victim_picker #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  ref_strobe,
    input  logic          victim_req,
    input  logic          fill_en,
    output logic [IW-1:0] victim_idx,
    output logic          victim_done
);
    logic [IW-1:0] hand_q;
    logic [IW-1:0] behind;
    logic [N-1:0]  ref_q;
    logic          cur_bit;
    logic          step;
    logic          clear_en;

    clkrep_hand #(.N(N), .IW(IW)) u_hand (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .hand_q (hand_q),
        .behind (behind)
    );

    clkrep_ref_bits #(.N(N), .IW(IW)) u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_strobe (ref_strobe),
        .fill_en    (fill_en),
        .behind     (behind),
        .clear_en   (clear_en),
        .hand       (hand_q),
        .ref_q      (ref_q),
        .cur_bit    (cur_bit)
    );

    clkrep_sweep #(.N(N), .IW(IW)) u_sweep (
        .clk         (clk),
        .rst_n       (rst_n),
        .victim_req  (victim_req),
        .cur_bit     (cur_bit),
        .hand        (hand_q),
        .step        (step),
        .clear_en    (clear_en),
        .victim_idx  (victim_idx),
        .victim_done (victim_done)
    );
endmodule

// File: rtl/clock_victim_picker_chk.sv
// Module: property checker for the clock victim selector, bound to the top.
// Observes ports plus the hand and flag state.
module clock_victim_picker_chk #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  ref_strobe,
    input logic          fill_en,
    input logic [IW-1:0] victim_idx,
    input logic          victim_done,
    input logic [N-1:0]  ref_q,
    input logic [IW-1:0] hand_q
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic [N-1:0]  prev_ref;
    logic [IW-1:0] hand_next;
    logic [IW-1:0] hand_back;

    // Purpose: keep the flag vector from before the latest edge
    always_ff @(posedge clk) begin
        if (!rst_n) prev_ref <= '0;
        else        prev_ref <= ref_q;
    end

    // Purpose: neighbours of the current hand position
    always_comb begin
        hand_next = (hand_q == LAST) ? '0 : hand_q + 1'b1;
        hand_back = (hand_q == '0) ? LAST : hand_q - 1'b1;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        victim_done |=> !victim_done);                                   // R9
    AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !victim_done |-> $stable(victim_idx));                           // R10
    AST_PICK_WAS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        victim_done |-> !prev_ref[victim_idx]);                          // R3
    AST_STROBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_strobe != '0) |=> ((ref_q & $past(ref_strobe)) == $past(ref_strobe))); // R8
    AST_HAND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hand_q == $past(hand_q)) || (hand_q == $past(hand_next))); // R6
    AST_FILL_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> ref_q[$past(hand_back)]);                            // R7
endmodule

bind clock_victim_picker clock_victim_picker_chk #(.N(N), .IW(IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_strobe  (ref_strobe),
    .fill_en     (fill_en),
    .victim_idx  (victim_idx),
    .victim_done (victim_done),
    .ref_q       (ref_q),
    .hand_q      (hand_q)
);

// File: tb/clock_victim_picker_tb_top.sv
// Directed bench for the clock victim selector: one task per scenario.
module clock_victim_picker_tb_top;
    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  ref_strobe;
    logic          victim_req;
    logic          fill_en;
    logic [IW-1:0] victim_idx;
    logic          victim_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    clock_victim_picker #(.N(N), .IW(IW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_strobe  (ref_strobe),
        .victim_req  (victim_req),
        .fill_en     (fill_en),
        .victim_idx  (victim_idx),
        .victim_done (victim_done)
    );

    task automatic check_eq(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Pulse a strobe mask for one cycle
    task automatic pulse_strobe(logic [N-1:0] mask);
        @(negedge clk); ref_strobe = mask;
        @(negedge clk); ref_strobe = '0;
    endtask

    // Pulse fill for one cycle
    task automatic pulse_fill();
        @(negedge clk); fill_en = 1'b1;
        @(negedge clk); fill_en = 1'b0;
    endtask

    // Count edges after the request edge until done is seen
    task automatic wait_done(int first, output int c);
        c = 0;
        for (int i = first; i <= N + 8; i++) begin
            @(posedge clk); @(negedge clk);
            if (victim_done) begin
                c = i;
                break;
            end
        end
    endtask

    // Issue one request and check index, latency and pulse width
    task automatic request(int exp_idx, int exp_cycles, string tag);
        int c;
        @(negedge clk); victim_req = 1'b1;
        @(posedge clk); @(negedge clk); victim_req = 1'b0;
        wait_done(1, c);
        check_eq({tag, " R5 latency"}, c, exp_cycles);
        check_eq({tag, " index"}, victim_idx, exp_idx);
        @(posedge clk); @(negedge clk);
        check_eq({tag, " R9 done width"}, victim_done, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ref_strobe = '0; victim_req = 1'b0; fill_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1 done in reset", victim_done, 0);
        check_eq("R1 index in reset", victim_idx, 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check_eq("R1 done after reset", victim_done, 0);
        request(0, 1, "R1 R3 fresh pick");
    endtask

    task automatic t_skip_flags();
        pulse_strobe(8'b0000_0110);
        request(3, 3, "R2 R3 R6 skip frames 1,2");
    endtask

    task automatic t_fill_and_clear();
        pulse_fill();                       // hand 4 -> marks frame 3
        pulse_strobe(8'b1111_0001);
        request(1, 6, "R2 R4 wrap to frame 1");
        request(2, 1, "R4 R6 frame 2 cleared earlier");
        request(4, 2, "R7 R4 fill flag on 3, 4 cleared");
    endtask

    task automatic t_all_set();
        pulse_strobe(8'hFF);
        request(5, 9, "R5 full revolution");
    endtask

    task automatic t_strobe_beats_clear();
        int c;
        pulse_strobe(8'hFF);                // hand is 6
        @(negedge clk); victim_req = 1'b1;
        @(posedge clk); @(negedge clk); victim_req = 1'b0;
        ref_strobe = 8'b0100_0000;          // coincides with clear of frame 6
        @(posedge clk); @(negedge clk); ref_strobe = '0;
        check_eq("R8 no early done", victim_done, 0);
        wait_done(2, c);
        check_eq("R8 latency with kept flag", c, 10);
        check_eq("R8 index after kept flag", victim_idx, 7);
    endtask

    task automatic t_busy_ignore();
        int c;
        int extra;
        pulse_strobe(8'hFF);                // hand is 0
        @(negedge clk); victim_req = 1'b1;
        @(posedge clk); @(negedge clk); victim_req = 1'b0;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk); victim_req = 1'b1;
        @(posedge clk); @(negedge clk); victim_req = 1'b0;
        wait_done(4, c);
        check_eq("R9 R5 busy sweep latency", c, 9);
        check_eq("R9 busy sweep index", victim_idx, 0);
        extra = 0;
        for (int i = 0; i < 12; i++) begin
            @(posedge clk); @(negedge clk);
            if (victim_done) extra++;
        end
        check_eq("R9 dropped request", extra, 0);
        check_eq("R10 index held", victim_idx, 0);
    endtask

    task automatic t_fill_repick();
        pulse_strobe(8'b1111_1100);
        pulse_fill();                       // hand 1 -> marks frame 0
        request(1, 1, "R3 frame 1 clear");
        request(1, 8, "R7 R4 frame 0 flagged by fill");
    endtask

    initial begin
        t_reset();
        t_skip_flags();
        t_fill_and_clear();
        t_all_set();
        t_strobe_beats_clear();
        t_busy_ignore();
        t_fill_repick();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule